// File: doc/BRIEF.md
# Sixteen-Bit Lookahead Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit that takes two operands and a three-bit operation code and returns a result of the same width, together with the carry out of the most significant bit. Every bit position is the same slice. Each slice conditions its operands for the selected operation and produces a generate and a propagate term. A two-level lookahead network turns those terms into the carry for every slice, with no chain rippling from bit to bit.

The slices are grouped four bits at a time. Each group reports a group generate and a group propagate. A second level combines the group terms into the carry entering each group. Inside each group, the first level then resolves the carries of the individual slices from the group's incoming carry.

Subtraction reverses the usual operand order and returns B minus A. The adder does this by inverting A and forcing the initial carry to one. Increment uses the same adder, with B zeroed and the initial carry forced to one. Two of the eight codes have no operation, and for them the result and the carry are zero.

Top module: `cla_alu`

## Requirements
- R1: Code 0 (binary 000) gives result = A + B modulo 2^16, and carry_out = bit 16 of the full sum.
- R2: Code 6 (binary 110) gives result = B − A modulo 2^16, and carry_out = 1 exactly when B ≥ A taken as unsigned values (no borrow).
- R3: Code 2 (binary 010) gives result = A + 1 modulo 2^16, and carry_out = 1 only when A = 0xFFFF. B has no effect.
- R4: Code 3 (binary 011) gives result = A with B ignored, and carry_out = 0.
- R5: Code 1 (binary 001) gives result = A XOR B bit by bit, and carry_out = 0.
- R6: Code 5 (binary 101) gives result = the bitwise complement of A XOR B, and carry_out = 0.
- R7: Codes 4 (binary 100) and 7 (binary 111) give result = 0 and carry_out = 0, whatever the operands.
- R8: A carry that starts in one four-bit group reaches bits in later groups, including runs that cross several group boundaries (0x0FFF + 1 = 0x1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| opcode | input | 3 | Operation select |
| result | output | 16 | Operation result |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The block holds no state, so a fault inside it shows at the ports as soon as the inputs settle. A wrong control decode shows for every operand pair of the affected code. A wrong group generate, group propagate or second-level term shows only when a carry has to cross a group boundary. The directed vectors therefore include carry runs that end exactly at 4, 8, 12 and 16 bits, in addition to the random pairs. A wrong forced initial carry shows as an off-by-one on subtraction and increment. Operand corners such as 0x8000 and 0xFFFF expose a fault in the carry-out term.

// File: rtl/cla_alu.sv
module cla_alu #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       opcode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int NGRP = WIDTH / GROUP;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_XOR  = 3'd1;
  localparam logic [2:0] OP_INC  = 3'd2;
  localparam logic [2:0] OP_PASS = 3'd3;
  localparam logic [2:0] OP_XNOR = 3'd5;
  localparam logic [2:0] OP_SUB  = 3'd6;

  logic inv_a, zero_b, cin0, use_logic, log_inv, kill, arith;

  always_comb begin
    inv_a = 1'b0; zero_b = 1'b0; cin0 = 1'b0;
    use_logic = 1'b0; log_inv = 1'b0; kill = 1'b0; arith = 1'b1;
    case (opcode)
      OP_ADD:  ;
      OP_SUB:  begin inv_a = 1'b1; cin0 = 1'b1; end
      OP_INC:  begin zero_b = 1'b1; cin0 = 1'b1; end
      OP_PASS: begin zero_b = 1'b1; arith = 1'b0; end
      OP_XOR:  begin use_logic = 1'b1; arith = 1'b0; end
      OP_XNOR: begin use_logic = 1'b1; log_inv = 1'b1; arith = 1'b0; end
      default: begin kill = 1'b1; arith = 1'b0; end
    endcase
  end

  logic [WIDTH-1:0] gen, prop;
  logic [WIDTH:0]   carry;
  logic [NGRP-1:0]  grp_g, grp_p;
  logic [NGRP:0]    grp_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic ae, be, lx;
    assign ae        = op_a[i] ^ inv_a;
    assign be        = op_b[i] & ~zero_b;
    assign gen[i]    = ae & be;
    assign prop[i]   = ae ^ be;
    assign lx        = op_a[i] ^ op_b[i] ^ log_inv;
    assign result[i] = kill ? 1'b0 : (use_logic ? lx : (prop[i] ^ carry[i]));
  end

  function automatic logic span(input logic [WIDTH-1:0] g, input logic [WIDTH-1:0] p,
                                input logic ci, input int k);
    logic acc, prod;
    acc = ci;
    for (int n = 0; n < k; n++) acc = acc & p[n];
    for (int m = 0; m < k; m++) begin
      prod = g[m];
      for (int n = m + 1; n < k; n++) prod = prod & p[n];
      acc = acc | prod;
    end
    return acc;
  endfunction

  always_comb begin
    logic [WIDTH-1:0] lg, lp;
    for (int j = 0; j < NGRP; j++) begin
      lg = gen >> (j * GROUP);
      lp = prop >> (j * GROUP);
      grp_g[j] = span(lg, lp, 1'b0, GROUP);
      grp_p[j] = &lp[GROUP-1:0];
    end
    lg = '0; lp = '0;
    lg[NGRP-1:0] = grp_g;
    lp[NGRP-1:0] = grp_p;
    for (int j = 0; j <= NGRP; j++) grp_c[j] = span(lg, lp, cin0, j);
    for (int j = 0; j < NGRP; j++) begin
      lg = gen >> (j * GROUP);
      lp = prop >> (j * GROUP);
      for (int k = 0; k < GROUP; k++) carry[j*GROUP + k] = span(lg, lp, grp_c[j], k);
    end
    carry[WIDTH] = grp_c[NGRP];
  end

  assign carry_out = arith & carry[WIDTH];
endmodule

// File: rtl/cla_alu_props.sv
module cla_alu_props #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       opcode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH:0] full;
  assign full = {carry_out, result};

  always_comb begin
    if (opcode == 3'd0)
      AST_ADD_SUM: assert (full == {1'b0, op_a} + {1'b0, op_b}); // R1
    if (opcode == 3'd6)
      AST_SUB_REVERSED: assert (full == {1'b0, op_b} + {1'b0, ~op_a} + 1); // R2
    if (opcode == 3'd2)
      AST_INC_ONE: assert (full == {1'b0, op_a} + 1); // R3
    if (opcode == 3'd3)
      AST_PASS_A: assert (full == {1'b0, op_a}); // R4
    if (opcode == 3'd1)
      AST_XOR_BITS: assert (full == {1'b0, op_a ^ op_b}); // R5
    if (opcode == 3'd5)
      AST_XNOR_BITS: assert (full == {1'b0, ~(op_a ^ op_b)}); // R6
    if (opcode == 3'd4 || opcode == 3'd7)
      AST_UNUSED_ZERO: assert (full == '0); // R7
  end
endmodule

bind cla_alu cla_alu_props #(.WIDTH(WIDTH)) u_props (
  .op_a(op_a), .op_b(op_b), .opcode(opcode), .result(result), .carry_out(carry_out)
);

// File: tb/test_cla_alu.sv
module test_cla_alu;
  logic        clk = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [2:0]  opcode = '0;
  logic [15:0] result;
  logic        carry_out;
  int applied = 0, miscompares = 0;

  always #10 clk = ~clk;

  cla_alu i_cla_alu (.op_a(op_a), .op_b(op_b), .opcode(opcode),
                     .result(result), .carry_out(carry_out));

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [16:0] exp;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{3'd0, 16'h0001, 16'h0002, 17'h00003},   // R1
    '{3'd0, 16'hFFFF, 16'h0001, 17'h10000},   // R1
    '{3'd0, 16'h8000, 16'h8000, 17'h10000},   // R1
    '{3'd0, 16'h00FF, 16'h0001, 17'h00100},   // R8
    '{3'd0, 16'h0FFF, 16'h0001, 17'h01000},   // R8
    '{3'd6, 16'h0003, 16'h0005, 17'h10002},   // R2
    '{3'd6, 16'h0005, 16'h0003, 17'h0FFFE},   // R2
    '{3'd6, 16'h0000, 16'h0000, 17'h10000},   // R2
    '{3'd2, 16'hFFFF, 16'h0000, 17'h10000},   // R3
    '{3'd2, 16'h1234, 16'hFFFF, 17'h01235},   // R3
    '{3'd3, 16'hABCD, 16'h1111, 17'h0ABCD},   // R4
    '{3'd1, 16'hF0F0, 16'hFF00, 17'h00FF0},   // R5
    '{3'd5, 16'hF0F0, 16'hFF00, 17'h0F00F},   // R6
    '{3'd4, 16'hFFFF, 16'hFFFF, 17'h00000},   // R7
    '{3'd7, 16'h8000, 16'h0001, 17'h00000}    // R7
  };

  function automatic logic [16:0] model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      3'd0: return {1'b0, a} + {1'b0, b};
      3'd6: return {(b >= a), b - a};
      3'd2: return {(a == 16'hFFFF), a + 16'd1};
      3'd3: return {1'b0, a};
      3'd1: return {1'b0, a ^ b};
      3'd5: return {1'b0, ~(a ^ b)};
      default: return 17'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd6: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd1: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [16:0] exp, input string req);
    @(posedge clk);
    opcode = op; op_a = a; op_b = b;
    @(negedge clk);
    applied++;
    if ({carry_out, result} !== exp) begin
      miscompares++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b,
               {carry_out, result}, exp);
    end
  endtask

  localparam logic [15:0] CORNERS [5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF};

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    apply(3'd0, 16'h0000, 16'h0000, 17'h00000, "R1");
    foreach (VECS[i]) apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].exp, tag(VECS[i].op));
    for (int k = 1; k <= 16; k++) begin
      logic [15:0] run = 16'((32'd1 << k) - 1);
      apply(3'd0, run, 16'h0001, {1'b0, run} + 17'd1, "R8");
    end
    for (int op = 0; op < 8; op++)
      foreach (CORNERS[x])
        foreach (CORNERS[y])
          apply(3'(op), CORNERS[x], CORNERS[y], model(3'(op), CORNERS[x], CORNERS[y]), tag(3'(op)));
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      logic [2:0]  op = 3'($urandom);
      apply(op, a, b, model(op, a, b), tag(op));
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule